// File: doc/BRIEF.md
# Timer Prescaler with Synchronized Reset

This block divides a source clock down for one timer/counter. A 10-bit prescaler counter advances on every source tick. A tap multiplexer turns a chosen counter wrap into a single-cycle count-enable pulse, so the timer advances at the selected ratio. The source tick is either every cycle of the system clock or each rising edge of a slow asynchronous oscillator input. That input is resynchronised into the system clock domain before use.

Software drives the block through a small register port with two addresses. The source register holds the 3-bit divide select and the source-select bit. The control register holds a prescaler-reset request bit and a hold-mode bit.

- **Normal mode:** a reset request clears the prescaler and then clears itself.
- **Hold mode:** the request stays set, so the prescaler stays in reset and the timer stays halted. Several such blocks can be halted this way and later released on the same cycle by clearing hold mode.

Top module: `tmr_prescale`

## Requirements
- R1: Divide select (source register bits [2:0]) decodes as 000 stop, 001 /1, 010 /8, 011 /32, 100 /64, 101 /128, 110 /256, 111 /1024. With a ratio N of 8 or more, `cnt_en` pulses exactly once every N source ticks and is never high on two cycles in a row.
- R2: With select 000, `cnt_en` never asserts.
- R3: With select 001 and the system clock as source, `cnt_en` is high on every cycle while no prescaler reset is pending.
- R4: Writing 1 to control bit 0 (address 1) with the system clock as source clears the prescaler on the following edge. The first pulse at ratio N then appears N+1 cycles after the write edge.
- R5: With the system clock as source and hold mode off, control bit 0 always reads as 0.
- R6: With the oscillator selected (source register bit 3 = 1), a written reset request reads as 1 at address 1 bit 0 until a synchronised oscillator rising edge has applied it, then reads 0.
- R7: With hold mode (control bit 7) set together with bit 0, the request reads back as 1, the prescaler is held in reset and `cnt_en` stays low.
- R8: In hold mode, rewriting control with bit 0 = 0 and bit 7 = 1 releases the prescaler, and at select /1 the first pulse follows one cycle after the write edge.
- R9: Clearing hold mode (writing control 0x00) while a request is held releases the prescaler with a fixed latency, giving the first /1 pulse two cycles after the write edge. Bit 0 then reads 0.
- R10: After reset, both registers read 0 and `cnt_en` is low, with the system clock as source.
- R11: Changing the divide select does not clear the prescaler counter, so the first period after a change can be shorter than the new ratio.
- R12: With the oscillator as source, the prescaler advances once per oscillator rising edge. The rising edge that applies a pending reset does not count.
- R13: In normal mode, writing 0 to control bit 0 has no effect on the pulse phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | Asynchronous low-frequency oscillator input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 source register, 1 control register |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| cnt_en | output | 1 | Count-enable pulse for the timer |

## Verification
The hardest situation to reach is a reset request pending in the oscillator domain. It shows at the ports only as a bit reading one while no oscillator edge has arrived yet. To get there, the bench parks the oscillator input low, issues the request, and reads the bit over several cycles. It then raises the input once and confirms that the bit drops. It also checks that the edge spent on the reset does not advance the count, using the pulse total over a known number of oscillator edges.

// File: rtl/tps_pkg.sv
package tps_pkg;
    localparam int SEL_W  = 3;
    localparam int N_SEL  = 1 << SEL_W;
    localparam int REG_W  = 8;
    localparam int PSR_BIT  = 0;
    localparam int HOLD_BIT = 7;
    localparam int EXT_BIT  = 3;

    typedef enum logic [SEL_W-1:0] {
        DIV_OFF  = 3'd0,
        DIV_1    = 3'd1,
        DIV_8    = 3'd2,
        DIV_32   = 3'd3,
        DIV_64   = 3'd4,
        DIV_128  = 3'd5,
        DIV_256  = 3'd6,
        DIV_1024 = 3'd7
    } div_sel_e;

    // number of low counter bits that must all be one for a wrap at a tap
    function automatic int tap_bits(input int idx);
        case (idx)
            2: return 3;
            3: return 5;
            4: return 6;
            5: return 7;
            6: return 8;
            7: return 10;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/tps_src_tick.sv
module tps_src_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    input  logic ext,
    output logic tick
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;
    logic               osc_rise;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], osc_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign osc_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    assign tick     = ext ? osc_rise : 1'b1;
endmodule

// File: rtl/tps_tap_mux.sv
module tps_tap_mux
    import tps_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [N_SEL-1:0] hit_vec;

    for (genvar i = 0; i < N_SEL; i++) begin : g_tap
        if (i == 0) begin : g_off
            assign hit_vec[i] = 1'b0;
        end else if (i == 1) begin : g_pass
            assign hit_vec[i] = 1'b1;
        end else begin : g_div
            localparam int NB = tap_bits(i);
            assign hit_vec[i] = &cnt[NB-1:0];
        end
    end

    assign hit = hit_vec[sel];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tps_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_in,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             cnt_en
);
    localparam logic ADR_SRC = 1'b0;
    localparam logic ADR_CTL = 1'b1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             ext;
        logic             hold;
        logic             psr;
        logic             pulse;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    logic tick, hit, done, clr, keep, wr_src, wr_ctl;
    logic sel_unused_bits;
    logic [SEL_W-1:0] sel_q;
    logic ext_q, hold_q, psr_q, ctl_wr;

    tps_src_tick #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_in (osc_in),
        .ext    (s_q.ext),
        .tick   (tick)
    );

    tps_tap_mux #(.CNT_W(CNT_W)) u_tap (
        .cnt (s_q.cnt),
        .sel (s_q.sel),
        .hit (hit)
    );

    assign sel_unused_bits = ^wr_data[6:4];

    always_comb begin
        s_d    = s_q;
        wr_src = wr_en & (wr_addr == ADR_SRC);
        wr_ctl = wr_en & (wr_addr == ADR_CTL);
        // a request is applied on the next edge in the system domain,
        // or on a synchronised oscillator edge in the asynchronous domain
        done   = ~s_q.ext | tick;
        clr    = s_q.psr & (s_q.hold | done);
        keep   = s_q.psr & (s_q.hold | ~done);

        if (wr_src) begin
            s_d.sel = wr_data[SEL_W-1:0];
            s_d.ext = wr_data[EXT_BIT];
        end

        if (wr_ctl) begin
            s_d.hold = wr_data[HOLD_BIT];
            if (wr_data[PSR_BIT])       s_d.psr = 1'b1;
            else if (wr_data[HOLD_BIT]) s_d.psr = 1'b0;
            else                        s_d.psr = keep;
        end else begin
            s_d.psr = keep;
        end

        if (clr) begin
            s_d.cnt   = '0;
            s_d.pulse = 1'b0;
        end else if (tick) begin
            s_d.cnt   = s_q.cnt + 1'b1;
            s_d.pulse = hit;
        end else begin
            s_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_SRC) begin
            rd_data[SEL_W-1:0] = s_q.sel;
            rd_data[EXT_BIT]   = s_q.ext;
        end else begin
            rd_data[HOLD_BIT] = s_q.hold;
            rd_data[PSR_BIT]  = s_q.psr & (s_q.hold | s_q.ext);
        end
    end

    assign cnt_en = s_q.pulse;
    assign sel_q  = s_q.sel;
    assign ext_q  = s_q.ext;
    assign hold_q = s_q.hold;
    assign psr_q  = s_q.psr;
    assign ctl_wr = wr_ctl;
endmodule

// File: rtl/tps_chk.sv
module tps_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_en,
    input logic [2:0] sel_q,
    input logic       ext_q,
    input logic       hold_q,
    input logic       psr_q,
    input logic       ctl_wr
);
    a_r2_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'd0) |=> !cnt_en);

    a_r3_div1_every: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'd1 && !ext_q && !psr_q) |=> cnt_en);

    a_r7_hold_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && psr_q) |=> !cnt_en);

    a_r5_sys_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (psr_q && !hold_q && !ext_q && !ctl_wr) |=> !psr_q);

    a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && sel_q >= 3'd2 && $past(sel_q) >= 3'd2) |=> !cnt_en);
endmodule

bind tmr_prescale tps_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .sel_q  (sel_q),
    .ext_q  (ext_q),
    .hold_q (hold_q),
    .psr_q  (psr_q),
    .ctl_wr (ctl_wr)
);

// File: tb/sim_tmr_prescale.sv
module sim_tmr_prescale;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_in = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       cnt_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    localparam int VDIV [0:7] = '{0, 1, 8, 32, 64, 128, 256, 1024};

    always #2.5 clk = ~clk;

    tmr_prescale u0 (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cnt_en(cnt_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // call at a negedge; write is captured at the next posedge
    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_pulse(input int lim, output int k);
        k = 0;
        for (int i = 1; i <= lim; i++) begin
            @(posedge clk); @(negedge clk);
            if (cnt_en) begin k = i; break; end
        end
    endtask

    task automatic count_pulses(input int n, inout int c);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (cnt_en) c++;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int k, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk("R10 cnt_en", int'(cnt_en), 0);
        rd_addr = 1'b0; #0.1; chk("R10 src reg", int'(rd_data), 0);
        rd_addr = 1'b1; #0.1; chk("R10 ctl reg", int'(rd_data), 0);
        @(negedge clk);

        // R5 system source: request reads zero
        wr(1'b0, 8'h02);
        wr(1'b1, 8'h01);
        rd_addr = 1'b1; #0.1;
        chk("R5 psr read sys", int'(rd_data[0]), 0);
        @(negedge clk);

        // vector walk over every divide select: R1 R2 R3 R4
        for (int v = 0; v < 8; v++) begin
            wr(1'b0, 8'(v));
            wr(1'b1, 8'h01);
            wait_pulse(1100, k);
            if (v == 0) begin
                chk("R2 stop no pulse", k, 0);
            end else begin
                chk((v == 1) ? "R3 first /1 pulse" : "R4 first pulse after reset", k, VDIV[v] + 1);
                wait_pulse(1100, k);
                chk((v == 1) ? "R3 /1 period" : "R1 period", k, VDIV[v]);
            end
        end

        // R13 writing zero keeps phase (/8)
        wr(1'b0, 8'h02);
        wait_pulse(20, k);
        wr(1'b1, 8'h00);
        wait_pulse(20, k);
        chk("R13 zero write no effect", k, 7);

        // R11 select change keeps counter
        wr(1'b1, 8'h01);
        repeat (20) @(negedge clk);
        wr(1'b0, 8'h03);
        wait_pulse(40, k);
        chk("R11 short first period", k, 12);

        // R7 hold mode at /1
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h81);
        rd_addr = 1'b1; #0.1;
        chk("R7 held readback", int'(rd_data), 8'h81);
        @(negedge clk);
        c = 0;
        count_pulses(20, c);
        chk("R7 halted pulses", c, 0);

        // R8 rewrite in hold mode releases
        wr(1'b1, 8'h80);
        wait_pulse(10, k);
        chk("R8 release latency", k, 1);
        chk("R8 readback", int'(rd_data), 8'h80);

        // R9 clearing hold releases with fixed latency
        wr(1'b1, 8'h81);
        repeat (3) @(negedge clk);
        wr(1'b1, 8'h00);
        wait_pulse(10, k);
        chk("R9 release latency", k, 2);
        chk("R9 readback", int'(rd_data), 0);

        // R6 asynchronous source: request pending until oscillator edge
        osc_in = 1'b0;
        wr(1'b0, 8'h0A);
        wr(1'b1, 8'h01);
        chk("R6 pending read", int'(rd_data[0]), 1);
        repeat (6) @(negedge clk);
        chk("R6 still pending", int'(rd_data[0]), 1);
        osc_in = 1'b1;
        repeat (6) @(negedge clk);
        chk("R6 applied read", int'(rd_data[0]), 0);

        // R12 oscillator ticks drive the division
        osc_in = 1'b0;
        repeat (4) @(negedge clk);
        wr(1'b1, 8'h01);
        c = 0;
        for (int r = 0; r < 80; r++) begin
            osc_in = 1'b1;
            count_pulses(4, c);
            osc_in = 1'b0;
            count_pulses(4, c);
        end
        count_pulses(10, c);
        chk("R12 pulses over 80 edges", c, 9);
        chk("R12 request cleared", int'(rd_data[0]), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule